// File: doc/BRIEF.md
# Dual-Pool Physical Register Free List

This block tracks which physical registers a rename stage may hand out next. It keeps two first-in-first-out pools, one for integer registers and one for floating-point registers. Both pools live in one shared index space: integer registers take the indices from zero up to the integer physical count, and floating-point registers take the indices directly above. Each class has its own allocate request. The block grants the oldest free index of that class in the same cycle, and the pop commits at the next clock edge.

Freed registers come back through a unified release port or through a release port for each class. The unified port steers an index to the correct pool by comparing it with the integer physical count, and it drops indices beyond the total register count. A flat free-bit scoreboard over all physical registers detects double frees and stops such an index from being queued twice. The block reports a not-empty flag and a free count for each class, and it raises error outputs for an allocation from an empty pool, a double free, and an allocation whose scoreboard bit is already clear.

Top module: `fl_dual_pool`

## Requirements
- R1: After reset, the integer pool holds indices LOG_INT..PHYS_INT-1 in ascending order and the floating-point pool holds PHYS_INT+LOG_FP..PHYS_INT+PHYS_FP-1 in ascending order. The free counts are PHYS_INT-LOG_INT and PHYS_FP-LOG_FP. No error output is raised.
- R2: A granted allocation returns the oldest queued index of its class in the same cycle as the request, with the alloc-valid output high. The pop takes effect at the next rising clock edge.
- R3: On the unified release port, an index below PHYS_INT is queued in the integer pool. An index from PHYS_INT up to PHYS_INT+PHYS_FP-1 is queued in the floating-point pool.
- R4: On the unified release port, an index at or above PHYS_INT+PHYS_FP is ignored. Both counts stay unchanged and no error is raised.
- R5: An allocation request to an empty pool gives alloc-valid low, an alloc index of zero, and that class's empty-allocation error high in the same cycle. The pool's count stays unchanged.
- R6: Releasing an index whose free bit is set raises the double-free error in the same cycle, and the index is not queued again.
- R7: A class-specific release port queues an in-class index directly into its own pool and applies the same double-free check. An index outside that class's range on a class port is ignored without an error.
- R8: Allocation and release on the same pool in one cycle are both accepted, and the count changes by the net amount. A unified release and a class-port release to the same pool in one cycle are both queued, the unified one first.
- R9: When the same index arrives on the unified port and on a class port in one cycle, the unified release is accepted and the class-port release is flagged as a double free. The index is queued once.
- R10: The free count of each class equals the number of indices queued in that pool, and the not-empty flag is high exactly when that count is non-zero.
- R11: The stale-allocation error is raised when a granted index has a clear free bit. Under any input sequence of the ports it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_alloc_req | input | 1 | Request one integer register |
| int_alloc_valid | output | 1 | Integer grant this cycle |
| int_alloc_idx | output | IDXW | Granted integer index (zero when not granted) |
| fp_alloc_req | input | 1 | Request one floating-point register |
| fp_alloc_valid | output | 1 | Floating-point grant this cycle |
| fp_alloc_idx | output | IDXW | Granted floating-point index (zero when not granted) |
| rel_valid | input | 1 | Unified release strobe |
| rel_idx | input | IDXW | Unified released index |
| int_rel_valid | input | 1 | Integer-class release strobe |
| int_rel_idx | input | IDXW | Integer-class released index |
| fp_rel_valid | input | 1 | Floating-point-class release strobe |
| fp_rel_idx | input | IDXW | Floating-point-class released index |
| int_not_empty | output | 1 | Integer pool holds at least one index |
| fp_not_empty | output | 1 | Floating-point pool holds at least one index |
| int_free_cnt | output | ICW | Integer pool occupancy |
| fp_free_cnt | output | FCW | Floating-point pool occupancy |
| err_empty_int | output | 1 | Integer request while integer pool is empty |
| err_empty_fp | output | 1 | Floating-point request while floating-point pool is empty |
| err_double_free | output | 1 | A release hit an index that is already free |
| err_alloc_stale | output | 1 | A grant popped an index whose free bit is clear |

## Verification
A directed part first empties both pools from the reset state, which shows the ascending reset order and the empty-allocation response. A unified sweep then walks every encodable index, so the steering boundary at the integer count and the drop boundary at the total count are seen on both sides. A second sweep releases the same indices again, on the unified port and on both class ports, including wrong-class indices on the class ports, which separates double-free rejection from out-of-range dropping. Directed same-cycle cases then cover the net count change, the ordering of two pushes into one pool, and the same index arriving on two ports. A long seeded stream of mixed requests follows, and a queue model in the bench checks grant order, counts and flags on every cycle.

// File: rtl/fl_pkg.sv
package fl_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_INT  = 2'd1,
      SEL_FP   = 2'd2
   } pool_sel_e;

   function automatic int unsigned fl_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fl_pool.sv
module fl_pool #(
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned IDXW      = 5,
   parameter int unsigned BASE      = 0,
   parameter int unsigned INIT_SKIP = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           pop,
   input  logic                           push_a,
   input  logic [IDXW-1:0]                data_a,
   input  logic                           push_b,
   input  logic [IDXW-1:0]                data_b,
   output logic [IDXW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]     cnt,
   output logic                           not_empty
);
   localparam int unsigned PW       = fl_pkg::fl_bits(DEPTH);
   localparam int unsigned CW       = $clog2(DEPTH+1);
   localparam int unsigned INIT_CNT = DEPTH - INIT_SKIP;
   localparam bit          POW2     = (DEPTH == (1 << PW));

   if (INIT_SKIP > DEPTH) begin : g_bad_skip
      $error("fl_pool: INIT_SKIP exceeds DEPTH");
   end

   logic [IDXW-1:0] mem_q [DEPTH];
   logic [PW-1:0]   rd_q, wr_q;
   logic [PW-1:0]   rd_n1, wr_n1, wr_n2;
   logic [CW-1:0]   cnt_q;

   if (POW2) begin : g_wrap_natural
      assign rd_n1 = rd_q + PW'(1);
      assign wr_n1 = wr_q + PW'(1);
      assign wr_n2 = wr_q + PW'(2);
   end else begin : g_wrap_compare
      localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
      assign rd_n1 = (rd_q  == LAST) ? '0 : rd_q  + PW'(1);
      assign wr_n1 = (wr_q  == LAST) ? '0 : wr_q  + PW'(1);
      assign wr_n2 = (wr_n1 == LAST) ? '0 : wr_n1 + PW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= (i < INIT_CNT) ? IDXW'(BASE + INIT_SKIP + i) : '0;
         end
         rd_q  <= '0;
         wr_q  <= PW'(INIT_CNT % DEPTH);
         cnt_q <= CW'(INIT_CNT);
      end else begin
         if (push_a) mem_q[wr_q] <= data_a;
         if (push_b) mem_q[push_a ? wr_n1 : wr_q] <= data_b;
         if (pop)    rd_q <= rd_n1;
         if (push_a && push_b)      wr_q <= wr_n2;
         else if (push_a || push_b) wr_q <= wr_n1;
         cnt_q <= cnt_q + CW'(push_a) + CW'(push_b) - CW'(pop);
      end
   end

   assign head      = mem_q[rd_q];
   assign cnt       = cnt_q;
   assign not_empty = (cnt_q != '0);

   // R8: storage depth equals class size, so the occupancy never exceeds it
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R5: no pop is ever issued to an empty pool
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0));

endmodule

// File: rtl/fl_scoreboard.sv
module fl_scoreboard #(
   parameter int unsigned NREG  = 16,
   parameter int unsigned IW    = 5,
   parameter int unsigned NCLR  = 2,
   parameter int unsigned NSET  = 3,
   parameter int unsigned P_INT = 8,
   parameter int unsigned L_INT = 4,
   parameter int unsigned L_FP  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCLR-1:0]            clr_v,
   input  logic [NCLR-1:0][IW-1:0]    clr_idx,
   input  logic [NSET-1:0]            set_v,
   input  logic [NSET-1:0][IW-1:0]    set_idx,
   output logic [NREG-1:0]            free_q
);
   logic [NREG-1:0] free_d;
   logic            set_hits_free;

   always_comb begin
      free_d        = free_q;
      set_hits_free = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         for (int c = 0; c < NCLR; c++) begin
            if (clr_v[c] && clr_idx[c] == IW'(i)) free_d[i] = 1'b0;
         end
         for (int s = 0; s < NSET; s++) begin
            if (set_v[s] && set_idx[s] == IW'(i)) begin
               if (free_q[i]) set_hits_free = 1'b1;
               free_d[i] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            free_q[i] <= ((i >= L_INT) && (i < P_INT)) || (i >= P_INT + L_FP);
         end
      end else begin
         free_q <= free_d;
      end
   end

   // R6: an accepted release never targets a register that is already free
   assert_no_reset_of_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !set_hits_free);

endmodule

// File: rtl/fl_dual_pool.sv
module fl_dual_pool #(
   parameter int unsigned LOG_INT  = 4,
   parameter int unsigned PHYS_INT = 8,
   parameter int unsigned LOG_FP   = 4,
   parameter int unsigned PHYS_FP  = 8,
   localparam int unsigned PHYS_TOT = PHYS_INT + PHYS_FP,
   localparam int unsigned IDXW     = $clog2(PHYS_TOT + 1),
   localparam int unsigned ICW      = $clog2(PHYS_INT + 1),
   localparam int unsigned FCW      = $clog2(PHYS_FP + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            int_alloc_req,
   output logic            int_alloc_valid,
   output logic [IDXW-1:0] int_alloc_idx,
   input  logic            fp_alloc_req,
   output logic            fp_alloc_valid,
   output logic [IDXW-1:0] fp_alloc_idx,
   input  logic            rel_valid,
   input  logic [IDXW-1:0] rel_idx,
   input  logic            int_rel_valid,
   input  logic [IDXW-1:0] int_rel_idx,
   input  logic            fp_rel_valid,
   input  logic [IDXW-1:0] fp_rel_idx,
   output logic            int_not_empty,
   output logic            fp_not_empty,
   output logic [ICW-1:0]  int_free_cnt,
   output logic [FCW-1:0]  fp_free_cnt,
   output logic            err_empty_int,
   output logic            err_empty_fp,
   output logic            err_double_free,
   output logic            err_alloc_stale
);
   import fl_pkg::*;

   if (LOG_INT >= PHYS_INT || LOG_FP >= PHYS_FP) begin : g_bad_logical
      $error("fl_dual_pool: logical count must be below physical count");
   end
   if (PHYS_INT < 2 || PHYS_FP < 2) begin : g_bad_physical
      $error("fl_dual_pool: each class needs at least two physical registers");
   end

   localparam logic [IDXW-1:0] INT_END = IDXW'(PHYS_INT);
   localparam logic [IDXW-1:0] TOT_END = IDXW'(PHYS_TOT);

   function automatic logic is_free(input logic [PHYS_TOT-1:0] v,
                                    input logic [IDXW-1:0] ix);
      logic r;
      r = 1'b0;
      for (int i = 0; i < PHYS_TOT; i++) begin
         if (ix == IDXW'(i)) r = v[i];
      end
      return r;
   endfunction

   logic [PHYS_TOT-1:0] free_q;
   logic [IDXW-1:0]     int_head, fp_head;

   // ---------------- allocation side ----------------
   always_comb begin
      int_alloc_valid = int_alloc_req && int_not_empty;
      fp_alloc_valid  = fp_alloc_req  && fp_not_empty;
      int_alloc_idx   = int_alloc_valid ? int_head : '0;
      fp_alloc_idx    = fp_alloc_valid  ? fp_head  : '0;
      err_empty_int   = int_alloc_req && !int_not_empty;
      err_empty_fp    = fp_alloc_req  && !fp_not_empty;
      err_alloc_stale = (int_alloc_valid && !is_free(free_q, int_head)) ||
                        (fp_alloc_valid  && !is_free(free_q, fp_head));
   end

   // ---------------- release side ----------------
   pool_sel_e u_sel;
   logic u_dbl, u_acc, ci_in, ci_dbl, ci_acc, cf_in, cf_dbl, cf_acc;

   always_comb begin
      if (!rel_valid)               u_sel = SEL_NONE;
      else if (rel_idx < INT_END)   u_sel = SEL_INT;
      else if (rel_idx < TOT_END)   u_sel = SEL_FP;
      else                          u_sel = SEL_NONE;

      u_dbl  = (u_sel != SEL_NONE) && is_free(free_q, rel_idx);
      u_acc  = (u_sel != SEL_NONE) && !u_dbl;

      ci_in  = int_rel_valid && (int_rel_idx < INT_END);
      ci_dbl = ci_in && (is_free(free_q, int_rel_idx) ||
                         (u_acc && rel_idx == int_rel_idx));
      ci_acc = ci_in && !ci_dbl;

      cf_in  = fp_rel_valid && (fp_rel_idx >= INT_END) && (fp_rel_idx < TOT_END);
      cf_dbl = cf_in && (is_free(free_q, fp_rel_idx) ||
                         (u_acc && rel_idx == fp_rel_idx));
      cf_acc = cf_in && !cf_dbl;

      err_double_free = u_dbl || ci_dbl || cf_dbl;
   end

   logic int_push_u, fp_push_u;
   assign int_push_u = u_acc && (u_sel == SEL_INT);
   assign fp_push_u  = u_acc && (u_sel == SEL_FP);

   // ---------------- pools ----------------
   fl_pool #(
      .DEPTH(PHYS_INT), .IDXW(IDXW), .BASE(0), .INIT_SKIP(LOG_INT)
   ) u_int_pool (
      .clk(clk), .rst_n(rst_n),
      .pop(int_alloc_valid),
      .push_a(int_push_u), .data_a(rel_idx),
      .push_b(ci_acc),     .data_b(int_rel_idx),
      .head(int_head), .cnt(int_free_cnt), .not_empty(int_not_empty)
   );

   fl_pool #(
      .DEPTH(PHYS_FP), .IDXW(IDXW), .BASE(PHYS_INT), .INIT_SKIP(LOG_FP)
   ) u_fp_pool (
      .clk(clk), .rst_n(rst_n),
      .pop(fp_alloc_valid),
      .push_a(fp_push_u), .data_a(rel_idx),
      .push_b(cf_acc),    .data_b(fp_rel_idx),
      .head(fp_head), .cnt(fp_free_cnt), .not_empty(fp_not_empty)
   );

   // ---------------- free-bit scoreboard ----------------
   fl_scoreboard #(
      .NREG(PHYS_TOT), .IW(IDXW), .NCLR(2), .NSET(3),
      .P_INT(PHYS_INT), .L_INT(LOG_INT), .L_FP(LOG_FP)
   ) u_sb (
      .clk(clk), .rst_n(rst_n),
      .clr_v({fp_alloc_valid, int_alloc_valid}),
      .clr_idx({fp_head, int_head}),
      .set_v({cf_acc, ci_acc, u_acc}),
      .set_idx({fp_rel_idx, int_rel_idx, rel_idx}),
      .free_q(free_q)
   );

   // ---------------- assertions ----------------
   // R11: every granted index is marked free in the scoreboard
   assert_grant_is_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int_alloc_valid |-> is_free(free_q, int_alloc_idx));

   // R5: an empty-pool request with nothing pushed leaves the pool empty
   assert_empty_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_empty_int && !int_push_u && !ci_acc) |=> (int_free_cnt == '0));

   // R4: a high unified index with no other traffic leaves both counts alone
   assert_drop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && rel_idx >= TOT_END && !int_rel_valid && !fp_rel_valid &&
       !int_alloc_req && !fp_alloc_req)
      |=> (int_free_cnt == $past(int_free_cnt) && fp_free_cnt == $past(fp_free_cnt)));

   // R3: an accepted unified release is marked free on the next cycle
   assert_release_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      u_acc |=> is_free(free_q, $past(rel_idx)));

   // R6: a rejected integer release on its own does not grow the pool
   assert_dbl_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (u_dbl && u_sel == SEL_INT && !int_rel_valid && !int_alloc_req)
      |=> (int_free_cnt == $past(int_free_cnt)));

endmodule

// File: tb/fl_dual_pool_test.sv
`timescale 1ns/1ps
module fl_dual_pool_test;
   localparam int LI = 4, PI = 8, LF = 4, PF = 8;
   localparam int PT = PI + PF;
   localparam int IW = $clog2(PT + 1);
   localparam int ICW = $clog2(PI + 1);
   localparam int FCW = $clog2(PF + 1);
   localparam int IDXMAX = (1 << IW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          int_alloc_req = 0, fp_alloc_req = 0;
   logic          rel_valid = 0, int_rel_valid = 0, fp_rel_valid = 0;
   logic [IW-1:0] rel_idx = 0, int_rel_idx = 0, fp_rel_idx = 0;
   logic          int_alloc_valid, fp_alloc_valid, int_not_empty, fp_not_empty;
   logic [IW-1:0] int_alloc_idx, fp_alloc_idx;
   logic [ICW-1:0] int_free_cnt;
   logic [FCW-1:0] fp_free_cnt;
   logic          err_empty_int, err_empty_fp, err_double_free, err_alloc_stale;

   fl_dual_pool #(.LOG_INT(LI), .PHYS_INT(PI), .LOG_FP(LF), .PHYS_FP(PF)) uut (
      .clk(clk), .rst_n(rst_n),
      .int_alloc_req(int_alloc_req), .int_alloc_valid(int_alloc_valid),
      .int_alloc_idx(int_alloc_idx),
      .fp_alloc_req(fp_alloc_req), .fp_alloc_valid(fp_alloc_valid),
      .fp_alloc_idx(fp_alloc_idx),
      .rel_valid(rel_valid), .rel_idx(rel_idx),
      .int_rel_valid(int_rel_valid), .int_rel_idx(int_rel_idx),
      .fp_rel_valid(fp_rel_valid), .fp_rel_idx(fp_rel_idx),
      .int_not_empty(int_not_empty), .fp_not_empty(fp_not_empty),
      .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt),
      .err_empty_int(err_empty_int), .err_empty_fp(err_empty_fp),
      .err_double_free(err_double_free), .err_alloc_stale(err_alloc_stale)
   );

   int n_vec = 0, n_bad = 0;
   int mq_i[$], mq_f[$];
   bit mfree[PT];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // One cycle: drive at the falling edge, compare before the rising edge,
   // then advance the model as the rising edge commits.
   task automatic step(input string tag, input bit ireq, input bit freq,
                       input bit rv, input int ridx, input bit irv, input int iridx,
                       input bit frv, input int fridx);
      bit e_iv, e_fv, u_in, u_dbl, u_acc, ci_in, ci_dbl, ci_acc, cf_in, cf_dbl, cf_acc;
      int e_ii, e_fi;
      @(negedge clk);
      int_alloc_req = ireq; fp_alloc_req = freq;
      rel_valid = rv; rel_idx = IW'(ridx);
      int_rel_valid = irv; int_rel_idx = IW'(iridx);
      fp_rel_valid = frv; fp_rel_idx = IW'(fridx);
      #2;
      e_iv = ireq && mq_i.size() > 0;
      e_fv = freq && mq_f.size() > 0;
      e_ii = e_iv ? mq_i[0] : 0;
      e_fi = e_fv ? mq_f[0] : 0;
      u_in  = rv && ridx < PT;
      u_dbl = u_in && mfree[ridx];
      u_acc = u_in && !u_dbl;
      ci_in  = irv && iridx < PI;
      ci_dbl = ci_in && (mfree[iridx] || (u_acc && ridx == iridx));
      ci_acc = ci_in && !ci_dbl;
      cf_in  = frv && fridx >= PI && fridx < PT;
      cf_dbl = cf_in && (mfree[fridx] || (u_acc && ridx == fridx));
      cf_acc = cf_in && !cf_dbl;

      chk(tag, "int_alloc_valid", int_alloc_valid, e_iv);
      chk(tag, "int_alloc_idx",   int_alloc_idx,   e_ii);
      chk(tag, "fp_alloc_valid",  fp_alloc_valid,  e_fv);
      chk(tag, "fp_alloc_idx",    fp_alloc_idx,    e_fi);
      chk(tag, "err_empty_int",   err_empty_int,   ireq && mq_i.size() == 0);
      chk(tag, "err_empty_fp",    err_empty_fp,    freq && mq_f.size() == 0);
      chk(tag, "err_double_free", err_double_free, u_dbl || ci_dbl || cf_dbl);
      chk(tag, "int_free_cnt",    int_free_cnt,    mq_i.size());
      chk(tag, "fp_free_cnt",     fp_free_cnt,     mq_f.size());
      chk(tag, "int_not_empty",   int_not_empty,   mq_i.size() != 0);
      chk(tag, "fp_not_empty",    fp_not_empty,    mq_f.size() != 0);
      chk("R11", "err_alloc_stale", err_alloc_stale, 0);

      if (e_iv) begin mfree[mq_i[0]] = 0; void'(mq_i.pop_front()); end
      if (e_fv) begin mfree[mq_f[0]] = 0; void'(mq_f.pop_front()); end
      if (u_acc) begin
         mfree[ridx] = 1;
         if (ridx < PI) mq_i.push_back(ridx); else mq_f.push_back(ridx);
      end
      if (ci_acc) begin mfree[iridx] = 1; mq_i.push_back(iridx); end
      if (cf_acc) begin mfree[fridx] = 1; mq_f.push_back(fridx); end
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
   end

   initial begin
      // R1: reset model
      for (int i = 0; i < PT; i++) mfree[i] = ((i >= LI) && (i < PI)) || (i >= PI + LF);
      for (int i = LI; i < PI; i++) mq_i.push_back(i);
      for (int i = PI + LF; i < PT; i++) mq_f.push_back(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
      // R1 R2: drain both pools in ascending reset order
      for (int k = 0; k < PI - LI; k++) step("R1", 1, 1, 0, 0, 0, 0, 0, 0);
      // R5: requests to empty pools
      step("R5", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R5", 0, 1, 0, 0, 0, 0, 0, 0);
      step("R5", 1, 1, 0, 0, 0, 0, 0, 0);

      // R3 R4: unified sweep over every encodable index
      for (int x = 0; x < IDXMAX; x++) step((x < PT) ? "R3" : "R4", 0, 0, 1, x, 0, 0, 0, 0);
      step("R10", 0, 0, 0, 0, 0, 0, 0, 0);

      // R6: every index released again on the unified port
      for (int x = 0; x < PT; x++) step("R6", 0, 0, 1, x, 0, 0, 0, 0);
      // R7: class ports with in-class (double) and wrong-class (ignored) indices
      for (int x = 0; x < IDXMAX; x++) step("R7", 0, 0, 0, 0, 1, x, 1, x);

      // R2: grant order equals unified sweep order
      for (int k = 0; k < PI; k++) step("R2", 1, 1, 0, 0, 0, 0, 0, 0);
      step("R5", 1, 1, 0, 0, 0, 0, 0, 0);

      // R7: class ports push into their own pools
      step("R7", 0, 0, 0, 0, 1, 3, 1, 9);
      step("R2", 1, 1, 0, 0, 0, 0, 0, 0);
      // R8: allocate and release together, net count
      step("R8", 0, 0, 1, 0, 0, 0, 1, 10);
      step("R8", 1, 1, 0, 0, 1, 1, 1, 11);
      step("R8", 1, 1, 1, 2, 0, 0, 1, 12);
      // R8: unified and class release into one pool, unified first
      step("R8", 0, 0, 1, 4, 1, 5, 0, 0);
      step("R8", 0, 0, 1, 13, 0, 0, 1, 14);
      // R9: same index on two ports
      step("R9", 0, 0, 1, 6, 1, 6, 0, 0);
      step("R9", 0, 0, 1, 15, 0, 0, 1, 15);
      for (int k = 0; k < 6; k++) step("R8", 1, 1, 0, 0, 0, 0, 0, 0);

      // R10: seeded mixed traffic against the queue model
      for (int k = 0; k < 3000; k++) begin
         automatic int r = $urandom;
         step("R10", r[0], r[1], r[2], (r >> 8) % 20, r[3], (r >> 16) % 12,
              r[4], 4 + ((r >> 24) % 16));
      end
      step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
      summary();
   end
endmodule